// File: doc/BRIEF.md
# PS/2 Device-Side Serial Transceiver

This block is the peripheral end of a two-wire PS/2 link, the end a keyboard or pointing device would carry. It owns the bus clock. It shifts bytes out toward the host. When the host asks to talk, it clocks in the host's frame, checks it and returns the handshake. Neither wire is ever driven high. Each wire is modelled as a drive-low enable going out and a sampled level coming back, and external pull-ups provide the high level.

Every frame carries 11 bits, least significant first:

- a start bit of 0,
- eight data bits, D0 first,
- a parity bit that makes the count of ones across data and parity odd,
- a stop bit of 1.

The generated clock runs only while a frame moves. Each half-period lasts a parameterised time, 40 us by default, counted from a system-frequency parameter. Both returning line levels pass through a two-flop synchronizer and a stability filter before any decision is taken.

The client sends a byte by pulsing `tx_valid` with the byte on `tx_data` while `busy` is low. Bytes that arrive from the host appear as a one-cycle `rx_strobe` with `rx_data`. A frame with bad parity gives a one-cycle `rx_err` instead.

Top module: `ps2d_xcvr`

## Requirements
- R1: After reset, and in every cycle where `busy` is low, both drive-low enables are 0. After reset `busy`, `rx_strobe` and `rx_err` are 0.
- R2: A byte accepted from the client leaves as 11 bits in this order: start bit 0, D0 to D7, odd parity, stop bit 1. The host reads each bit at a falling edge of the bus clock.
- R3: Every low pulse of the generated clock lasts exactly PHASE cycles, and so does every released phase inside a frame. PHASE = (SYS_HZ / 1,000,000) * PHASE_US, which is 4000 at the defaults.
- R4: The device changes its data enable only in cycles where its clock enable is 0, that is, only while the clock is high.
- R5: A `tx_valid` pulse is taken only in a cycle where `busy` is low. A pulse while `busy` is high is dropped and sends nothing.
- R6: While the host holds the clock low, `busy` stays high and the device pulls neither line.
- R7: The host requests to send by releasing the clock while it holds data low. The device then treats that low level as the start bit and generates 10 more clock pulses. It samples data in the last cycle of each released phase: D0 to D7, then parity, then the stop bit.
- R8: After the stop bit, the device pulls data low for one phase with the clock released. It then also pulls the clock low for one phase, and then releases both lines.
- R9: A host frame with odd parity gives `rx_strobe` for exactly one cycle with the byte on `rx_data`. A frame with even parity gives `rx_err` for exactly one cycle and no strobe. Either pulse starts on the edge that ends the handshake clock pulse.
- R10: The host may pull the clock low during a released phase of a transmit, once FILT_LEN+4 cycles of that phase have passed. The device then abandons the byte, releases data, and waits for the host's release so it can handle a request-to-send.
- R11: A change on either line takes effect only after the synchronized level has held for FILT_LEN cycles. A clock-low glitch of 2 cycles in idle leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_clk_in | input | 1 | Sampled level of the PS/2 clock wire |
| bus_dat_in | input | 1 | Sampled level of the PS/2 data wire |
| bus_clk_low | output | 1 | Pull the clock wire low when 1, release when 0 |
| bus_dat_low | output | 1 | Pull the data wire low when 1, release when 0 |
| tx_data | input | 8 | Byte to send to the host |
| tx_valid | input | 1 | One-cycle send request, honoured while busy is low |
| busy | output | 1 | Block is moving a frame, the host is inhibiting, or the clock line reads low |
| rx_data | output | 8 | Last byte received from the host |
| rx_strobe | output | 1 | One-cycle pulse: rx_data holds a new good byte |
| rx_err | output | 1 | One-cycle pulse: host frame failed its parity check |

## Verification
A send request taken at one edge pulls the data line low for the start bit from that edge. The first clock pulse follows PHASE cycles later, and the frame ends 23 phases after acceptance. For a host frame, the result pulse rises on the same edge that releases the handshake clock pulse. That edge comes 22 phases after the device first answers the request-to-send, and the answer needs only the filter latency of about FILT_LEN+3 cycles.

The bench does not count these cycles blindly. Its host model waits on bus clock edges, and the scoreboard pops an expected item only when the design produces a frame or a result pulse. Pulse widths are measured against PHASE as they happen, and immediate port checks run a fixed number of cycles after inhibit, glitch and abort stimuli.

// File: rtl/ps2d_pkg.sv
package ps2d_pkg;

    localparam int FRAME_BITS = 11;   // start, 8 data, parity, stop
    localparam int RX_CLOCKS  = 10;   // pulses after the host start bit
    localparam int RX_KEEP    = 9;    // data + parity kept in the shifter
    localparam int LN_CLK     = 0;
    localparam int LN_DAT     = 1;
    localparam int N_LINES    = 2;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_INHIBIT,
        ST_TX_HI,
        ST_TX_LO,
        ST_TX_END,
        ST_RX_LO,
        ST_RX_HI,
        ST_ACK_D,
        ST_ACK_C,
        ST_TAIL
    } ps2d_state_e;

    typedef struct packed {
        logic       par;
        logic [7:0] data;
    } rx_bits_t;

    function automatic int phase_cycles(input int sys_hz, input int phase_us);
        return (sys_hz / 1_000_000) * phase_us;
    endfunction

    function automatic logic odd_parity(input logic [7:0] d);
        return ~(^d);
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] d);
        return {1'b1, odd_parity(d), d, 1'b0};
    endfunction

    function automatic logic parity_good(input rx_bits_t r);
        return ^{r.par, r.data};
    endfunction

endpackage

// File: rtl/ps2d_linefilt.sv
module ps2d_linefilt #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN) + 1;

    logic [1:0]    sync_q;
    logic [CW-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b11;
            hold_q <= '0;
            clean  <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], raw};
            if (sync_q[1] == clean) begin
                hold_q <= '0;
            end else if (hold_q == CW'(FILT_LEN - 1)) begin
                clean  <= sync_q[1];
                hold_q <= '0;
            end else begin
                hold_q <= hold_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ps2d_phase_timer.sv
module ps2d_phase_timer #(
    parameter int PHASE  = 4000,
    parameter int SETTLE = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic last,
    output logic settled
);
    localparam int TW = $clog2(PHASE) + 1;

    logic [TW-1:0] cnt_q;

    assign last    = (cnt_q == TW'(PHASE - 1));
    assign settled = (cnt_q >= TW'(SETTLE));

    always_ff @(posedge clk) begin
        if (rst || restart || last) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/ps2d_engine.sv
module ps2d_engine
    import ps2d_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clk_f,
    input  logic       dat_f,
    input  logic       ph_last,
    input  logic       ph_settled,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       ph_restart,
    output logic       busy,
    output logic       clk_low,
    output logic       dat_low,
    output logic [7:0] rx_data,
    output logic       rx_strobe,
    output logic       rx_err
);
    ps2d_state_e           st, nxt;
    logic [FRAME_BITS-1:0] frame, nfr;
    logic [3:0]            bitn, nbit;
    rx_bits_t              rx_sh, nrx;
    logic                  deliver;
    logic                  good;

    assign ph_restart = (st == ST_IDLE) || (st == ST_INHIBIT);
    assign busy       = (st != ST_IDLE) || !clk_f;
    assign good       = parity_good(rx_sh);

    always_comb begin
        nxt     = st;
        nfr     = frame;
        nbit    = bitn;
        nrx     = rx_sh;
        deliver = 1'b0;
        case (st)
            ST_IDLE: begin
                if (!clk_f) begin
                    nxt = ST_INHIBIT;
                end else if (tx_valid) begin
                    nxt  = ST_TX_HI;
                    nfr  = build_frame(tx_data);
                    nbit = '0;
                end
            end
            ST_INHIBIT: begin
                if (clk_f) begin
                    nbit = '0;
                    nxt  = dat_f ? ST_IDLE : ST_RX_LO;
                end
            end
            ST_TX_HI: begin
                if (ph_settled && !clk_f) nxt = ST_INHIBIT;
                else if (ph_last)         nxt = ST_TX_LO;
            end
            ST_TX_LO: begin
                if (ph_last) begin
                    if (bitn == 4'(FRAME_BITS - 1)) begin
                        nxt = ST_TX_END;
                    end else begin
                        nxt  = ST_TX_HI;
                        nfr  = frame >> 1;
                        nbit = bitn + 1'b1;
                    end
                end
            end
            ST_TX_END: if (ph_last) nxt = ST_IDLE;
            ST_RX_LO:  if (ph_last) nxt = ST_RX_HI;
            ST_RX_HI: begin
                if (ph_last) begin
                    if (bitn < 4'(RX_KEEP)) nrx = {dat_f, rx_sh[RX_KEEP-1:1]};
                    if (bitn == 4'(RX_CLOCKS - 1)) begin
                        nxt = ST_ACK_D;
                    end else begin
                        nxt  = ST_RX_LO;
                        nbit = bitn + 1'b1;
                    end
                end
            end
            ST_ACK_D: if (ph_last) nxt = ST_ACK_C;
            ST_ACK_C: begin
                if (ph_last) begin
                    nxt     = ST_TAIL;
                    deliver = 1'b1;
                end
            end
            ST_TAIL:  if (ph_last) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            frame     <= '0;
            bitn      <= '0;
            rx_sh     <= '0;
            clk_low   <= 1'b0;
            dat_low   <= 1'b0;
            rx_data   <= '0;
            rx_strobe <= 1'b0;
            rx_err    <= 1'b0;
        end else begin
            st        <= nxt;
            frame     <= nfr;
            bitn      <= nbit;
            rx_sh     <= nrx;
            clk_low   <= (nxt == ST_TX_LO) || (nxt == ST_RX_LO) || (nxt == ST_ACK_C);
            dat_low   <= (((nxt == ST_TX_HI) || (nxt == ST_TX_LO)) && !nfr[0])
                         || (nxt == ST_ACK_D) || (nxt == ST_ACK_C);
            rx_strobe <= deliver && good;
            rx_err    <= deliver && !good;
            if (deliver && good) rx_data <= rx_sh.data;
        end
    end
endmodule

// File: rtl/ps2d_xcvr.sv
module ps2d_xcvr
    import ps2d_pkg::*;
#(
    parameter int SYS_HZ   = 100_000_000,
    parameter int PHASE_US = 40,
    parameter int FILT_LEN = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_clk_in,
    input  logic       bus_dat_in,
    output logic       bus_clk_low,
    output logic       bus_dat_low,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       busy,
    output logic [7:0] rx_data,
    output logic       rx_strobe,
    output logic       rx_err
);
    localparam int PHASE_CYC  = phase_cycles(SYS_HZ, PHASE_US);
    localparam int SETTLE_CYC = FILT_LEN + 4;

    logic [N_LINES-1:0] raw, clean;
    logic               ph_last, ph_settled, ph_restart;

    assign raw[LN_CLK] = bus_clk_in;
    assign raw[LN_DAT] = bus_dat_in;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        ps2d_linefilt #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk   (clk),
            .rst   (rst),
            .raw   (raw[g]),
            .clean (clean[g])
        );
    end

    ps2d_phase_timer #(.PHASE(PHASE_CYC), .SETTLE(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (ph_restart),
        .last    (ph_last),
        .settled (ph_settled)
    );

    ps2d_engine u_eng (
        .clk        (clk),
        .rst        (rst),
        .clk_f      (clean[LN_CLK]),
        .dat_f      (clean[LN_DAT]),
        .ph_last    (ph_last),
        .ph_settled (ph_settled),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .ph_restart (ph_restart),
        .busy       (busy),
        .clk_low    (bus_clk_low),
        .dat_low    (bus_dat_low),
        .rx_data    (rx_data),
        .rx_strobe  (rx_strobe),
        .rx_err     (rx_err)
    );
endmodule

// File: rtl/ps2d_xcvr_chk.sv
module ps2d_xcvr_chk #(
    parameter int PHASE = 4000
) (
    input logic clk,
    input logic rst,
    input logic clk_pull,
    input logic dat_pull,
    input logic busy,
    input logic rx_strobe,
    input logic rx_err
);
    int lo_cnt;

    always_ff @(posedge clk) begin
        if (rst)           lo_cnt <= 0;
        else if (clk_pull) lo_cnt <= lo_cnt + 1;
        else               lo_cnt <= 0;
    end

    // R1
    idle_release_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!clk_pull && !dat_pull));

    // R3
    phase_width_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_pull) |-> (lo_cnt == PHASE));

    // R4
    data_moves_high_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(dat_pull) |-> !clk_pull);

    // R8
    ack_order_chk: assert property (@(posedge clk) disable iff (rst)
        (clk_pull && dat_pull) |-> $past(dat_pull));

    // R9
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_strobe |=> !rx_strobe);

    // R9
    err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rx_err |=> !rx_err);
endmodule

bind ps2d_xcvr ps2d_xcvr_chk #(.PHASE(PHASE_CYC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clk_pull  (bus_clk_low),
    .dat_pull  (bus_dat_low),
    .busy      (busy),
    .rx_strobe (rx_strobe),
    .rx_err    (rx_err)
);

// File: tb/sim_ps2d_xcvr.sv
module sim_ps2d_xcvr;
    localparam int PH = 40;          // 10 cycles per us * 4 us

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst = 1'b1;
    logic       h_clk_low = 1'b0, h_dat_low = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       dev_clk_low, dev_dat_low, busy, rx_strobe, rx_err;
    logic [7:0] rx_data;

    wire bclk = ~(dev_clk_low | h_clk_low);
    wire bdat = ~(dev_dat_low | h_dat_low);

    ps2d_xcvr #(.SYS_HZ(10_000_000), .PHASE_US(4), .FILT_LEN(4)) u0 (
        .clk(clk), .rst(rst), .bus_clk_in(bclk), .bus_dat_in(bdat),
        .bus_clk_low(dev_clk_low), .bus_dat_low(dev_dat_low),
        .tx_data(tx_data), .tx_valid(tx_valid), .busy(busy),
        .rx_data(rx_data), .rx_strobe(rx_strobe), .rx_err(rx_err)
    );

    int         checks = 0, errors = 0;
    bit         host_busy = 1'b0, done = 1'b0;
    logic [7:0] txq[$];
    logic [8:0] rxq[$];              // {bad, byte}

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // device-to-host frame monitor and clock width scoreboard
    logic        pclk = 1'b1;
    int          mcnt = 0, lw = 0;
    logic [10:0] mfr = '0;
    always @(negedge clk) begin
        if (rst || host_busy) begin
            mcnt = 0;
            lw   = 0;
        end else begin
            if (pclk && !bclk) begin
                mfr = {bdat, mfr[10:1]};
                mcnt++;
                if (mcnt == 11) begin
                    mcnt = 0;
                    if (txq.size() == 0) begin
                        chk(1'b0, "R2", "unexpected frame", int'(mfr), 0);
                    end else begin
                        logic [7:0] e;
                        e = txq.pop_front();
                        chk(mfr[0] == 1'b0, "R2", "start bit", mfr[0], 0);
                        chk(mfr[8:1] == e, "R2", "data bits", mfr[8:1], e);
                        chk(^mfr[9:1] == 1'b1, "R2", "odd parity", mfr[9], ~^e);
                        chk(mfr[10] == 1'b1, "R2", "stop bit", mfr[10], 1);
                    end
                end
            end
            if (!bclk) lw++;
            else if (lw != 0) begin
                chk(lw == PH, "R3", "clock low width", lw, PH);
                lw = 0;
            end
        end
        pclk = bclk;
    end

    // host-to-device result scoreboard
    always @(negedge clk) begin
        if (!rst && (rx_strobe || rx_err)) begin
            if (rxq.size() == 0) begin
                chk(1'b0, "R9", "unexpected result pulse", {rx_err, rx_strobe}, 0);
            end else begin
                logic [8:0] e;
                e = rxq.pop_front();
                if (e[8]) begin
                    chk(rx_err && !rx_strobe, "R9", "parity error flag",
                        {rx_err, rx_strobe}, 2'b10);
                end else begin
                    chk(rx_strobe && !rx_err, "R9", "good strobe",
                        {rx_err, rx_strobe}, 2'b01);
                    chk(rx_data == e[7:0], "R7", "received byte", rx_data, e[7:0]);
                end
            end
        end
    end

    task automatic wait_bclk_fall();
        logic p;
        p = bclk;
        @(negedge clk);
        while (!(p && !bclk)) begin
            p = bclk;
            @(negedge clk);
        end
    endtask

    task automatic dev_send(input logic [7:0] b, input bit expect_it);
        @(negedge clk);
        while (busy) @(negedge clk);
        tx_data  = b;
        tx_valid = 1'b1;
        if (expect_it) txq.push_back(b);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_tx_done();
        while (txq.size() != 0 || busy) @(negedge clk);
        repeat (10) @(negedge clk);
    endtask

    // R7: request-to-send, then the host places bits after each falling edge
    task automatic host_send(input logic [7:0] b, input bit bad, input bit clk_held);
        logic [9:0] bits;
        bits = {1'b1, odd_bit(b) ^ bad, b};
        host_busy = 1'b1;
        if (!clk_held) begin
            h_clk_low = 1'b1;
            repeat (150) @(negedge clk);
        end else begin
            repeat (120) @(negedge clk);
        end
        h_dat_low = 1'b1;
        rxq.push_back({bad, b});
        repeat (20) @(negedge clk);
        h_clk_low = 1'b0;
        for (int i = 0; i < 10; i++) begin
            wait_bclk_fall();
            h_dat_low = ~bits[i];
        end
        wait_bclk_fall();
        chk(bdat == 1'b0, "R8", "data low at handshake clock edge", bdat, 0);
        chk(dev_dat_low == 1'b1, "R8", "device pulls data for handshake", dev_dat_low, 1);
        while (!bclk) @(negedge clk);
        chk(bdat == 1'b1, "R8", "both lines released together", bdat, 1);
        repeat (PH + 20) @(negedge clk);
        host_busy = 1'b0;
    endtask

    function automatic logic odd_bit(input logic [7:0] d);
        return ~(^d);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(!dev_clk_low && !dev_dat_low, "R1", "lines released after reset",
            {dev_clk_low, dev_dat_low}, 0);
        chk(!rx_strobe && !rx_err, "R1", "no result after reset", {rx_strobe, rx_err}, 0);

        // R2, R3, R4: device frames
        dev_send(8'h00, 1'b1); wait_tx_done();
        dev_send(8'hFF, 1'b1); wait_tx_done();
        dev_send(8'hA5, 1'b1);
        // R5: request while busy is dropped
        chk(busy == 1'b1, "R5", "busy during transmit", busy, 1);
        tx_data = 8'h11; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        wait_tx_done();
        dev_send(8'h3C, 1'b1); wait_tx_done();
        repeat (3 * PH) @(negedge clk);
        chk(txq.size() == 0 && bclk && bdat, "R5", "no frame for dropped request",
            txq.size(), 0);

        // R7, R8, R9: host frames
        host_send(8'h6B, 1'b0, 1'b0);
        host_send(8'h80, 1'b0, 1'b0);
        host_send(8'h2D, 1'b1, 1'b0);

        // R6: inhibit blocks a send
        host_busy = 1'b1;
        h_clk_low = 1'b1;
        repeat (20) @(negedge clk);
        chk(busy == 1'b1, "R6", "busy while inhibited", busy, 1);
        tx_data = 8'h5A; tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        repeat (100) @(negedge clk);
        chk(!dev_clk_low && !dev_dat_low, "R6", "no pull while inhibited",
            {dev_clk_low, dev_dat_low}, 0);
        h_clk_low = 1'b0;
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R6", "idle after release with data high", busy, 0);
        repeat (3 * PH) @(negedge clk);
        chk(bdat == 1'b1 && bclk == 1'b1, "R6", "inhibited request sent nothing",
            {bclk, bdat}, 2'b11);
        host_busy = 1'b0;

        // R11: short clock glitch is filtered
        begin
            bit seen;
            seen = 1'b0;
            host_busy = 1'b1;
            h_clk_low = 1'b1;
            repeat (2) @(negedge clk);
            h_clk_low = 1'b0;
            for (int k = 0; k < 12; k++) begin
                if (busy) seen = 1'b1;
                @(negedge clk);
            end
            chk(!seen, "R11", "glitch raised busy", seen, 0);
            host_busy = 1'b0;
        end

        // R10: host aborts a transmit, then sends its own byte
        host_busy = 1'b1;
        dev_send(8'hE7, 1'b0);
        repeat (3) wait_bclk_fall();
        while (!bclk) @(negedge clk);
        repeat (15) @(negedge clk);
        h_clk_low = 1'b1;
        repeat (30) @(negedge clk);
        chk(!dev_clk_low && !dev_dat_low, "R10", "lines released after abort",
            {dev_clk_low, dev_dat_low}, 0);
        chk(busy == 1'b1, "R10", "busy while host holds clock", busy, 1);
        host_send(8'hC3, 1'b0, 1'b1);

        dev_send(8'h12, 1'b1); wait_tx_done();

        chk(txq.size() == 0, "R2", "all frames seen", txq.size(), 0);
        chk(rxq.size() == 0, "R9", "all results seen", rxq.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule